// File: doc/BRIEF.md
# Power-of-two clock divider with glitch-free gate

This block takes a reference clock, divides it by a power of two chosen through a small register port, and drives the result on one output. The output can be switched on and off without ever producing a shortened high phase. Software writes a 3-bit factor code into one register and an enable flag into another. The output then starts or stops within a fixed number of reference cycles, and that number depends on the current divisor. The register port is a simple write strobe with a combinational read. It runs on the reference clock.

The factor code is read as a base-two exponent plus one: the divisor is two to the power (code minus one), and code zero behaves exactly like code one. The enable request reaches the output gate through two stages that advance only at the divided clock's period boundaries. The gate therefore opens and closes only while the output is low. The divide counter holds at zero while the block is idle, so the first output period after enabling starts aligned and at full width. Each instance decodes the upper address bits against its own page, so several copies can share one address space at 0x100 spacing.

Top module: `pow2_clock_divider`

## Requirements
- R1: A register access counts only when `regAddr[15:8]` equals the instance page (default 0x01). A write to any other page changes nothing, and a read outside the page returns 0.
- R2: The factor code sits in bits [2:0] of window offset 0x43. Writes store those bits, and reads return them with bits [7:3] as zero.
- R3: The enable flag is bit 7 of window offset 0x46 and reads back as 0x80 or 0x00. Bits [6:0] of a write to that offset have no effect.
- R4: With code c, the divisor is d = 2^(c-1), and c = 0 gives d = 1. While enabled, `divClk` has a period of d reference cycles. For d ≥ 2 it is high for d/2 cycles and low for d/2 cycles. For d = 1 it follows the high phase of the reference clock.
- R5: After the enable write is registered, `divClk` shows its first high phase within 2 + 3·d reference cycles, and that first high phase has full width.
- R6: After the disable write is registered, `divClk` is low and stays low within 3·d reference cycles, and its last high phase has full width.
- R7: A factor write while enabled updates the register at once. The running divider takes the new divisor only at a period boundary, so every high and low phase has the full width of either the old divisor or the new one.
- R8: Reset clears the factor code to 0 and the enable flag to 0 and holds `divClk` low. Offsets inside the page other than 0x43 and 0x46 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; register port and divider logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe, sampled on the rising clock edge |
| regAddr | input | 16 | Register address: page in [15:8], offset in [7:0] |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for `regAddr` |
| divClk | output | 1 | Gated, divided clock output |

## Verification
If the divide counter or the loaded exponent is wrong, the very next complete high or low run of `divClk` has the wrong length. The bench measures run lengths at every half reference cycle, so this shows up within one divided period. If the gate or its synchroniser is wrong, the output either misses the on and off deadlines, which the bench checks against 2 + 3·d and 3·d, or it produces a high run shorter than d half-cycles at the gate edge. If the register decode is wrong, the fault appears at the read port on the next read, or as output activity after a write that should have been ignored.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;
  localparam int FACTOR_W = 3;
  localparam int DATA_W   = 8;
  localparam int OFFSET_W = 8;
  // largest exponent reachable with the factor code (code max minus one)
  localparam int MAX_LOG  = (1 << FACTOR_W) - 2;
  localparam int LOG_W    = $clog2(MAX_LOG + 1);
  localparam int CNT_W    = (MAX_LOG > 0) ? MAX_LOG : 1;

  // strobes from the register side to the divider
  typedef struct packed {
    logic                enReq;
    logic [FACTOR_W-1:0] factor;
  } ctrl_t;

  // code 0 and code 1 both give exponent 0 (divide by one)
  function automatic logic [LOG_W-1:0] factorToLog(input logic [FACTOR_W-1:0] f);
    return (f == '0) ? '0 : LOG_W'(f - FACTOR_W'(1));
  endfunction

  // terminal count of the divide counter for a given exponent
  function automatic logic [CNT_W-1:0] lastCount(input logic [LOG_W-1:0] lg);
    return {CNT_W{1'b1}} >> (CNT_W - int'(lg));
  endfunction
endpackage

// File: rtl/pow2div_regs.sv
module pow2div_regs
  import pow2div_pkg::*;
#(
  parameter int                     ADDR_W      = 16,
  parameter logic [ADDR_W-OFFSET_W-1:0] WINDOW_PAGE = 8'h01,
  parameter logic [OFFSET_W-1:0]    FACTOR_OFS  = 8'h43,
  parameter logic [OFFSET_W-1:0]    ENABLE_OFS  = 8'h46,
  parameter int                     ENABLE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output ctrl_t             ctrl
);
  logic                pageHit;
  logic [OFFSET_W-1:0] offset;
  logic                hitFactor;
  logic                hitEnable;
  logic [FACTOR_W-1:0] factorReg;
  logic                enableReg;
  logic                unusedWdata;

  assign pageHit     = (regAddr[ADDR_W-1:OFFSET_W] == WINDOW_PAGE);
  assign offset      = regAddr[OFFSET_W-1:0];
  assign hitFactor   = pageHit && (offset == FACTOR_OFS);
  assign hitEnable   = pageHit && (offset == ENABLE_OFS);
  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      factorReg <= '0;
      enableReg <= 1'b0;
    end else if (regWr) begin
      if (hitFactor) factorReg <= regWdata[FACTOR_W-1:0];
      if (hitEnable) enableReg <= regWdata[ENABLE_BIT];
    end
  end

  always_comb begin
    regRdata = '0;
    if (hitFactor) regRdata[FACTOR_W-1:0] = factorReg;
    if (hitEnable) regRdata[ENABLE_BIT]   = enableReg;
  end

  assign ctrl.enReq  = enableReg;
  assign ctrl.factor = factorReg;

  // R1: writes outside the page leave both registers alone
  a_r1_foreign_page: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && !pageHit) |=> ($stable(factorReg) && $stable(enableReg)));

  // R2: a factor write stores the low bits of the data
  a_r2_factor_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && hitFactor) |=> (factorReg == $past(regWdata[FACTOR_W-1:0])));

  // R3: an enable write takes only the flag bit
  a_r3_enable_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && hitEnable) |=> (enableReg == $past(regWdata[ENABLE_BIT])));
endmodule

// File: rtl/pow2div_core.sv
module pow2div_core
  import pow2div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  output logic  divClk
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntN;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] lastIdxN;
  logic [LOG_W-1:0] curLog;
  logic [LOG_W-1:0] nxtLog;
  logic [LOG_W-1:0] reqLog;
  logic             run;
  logic             wrap;
  logic             syncA, syncAN;
  logic             syncB, syncBN;
  logic             outReg, outRegN;
  logic             gateLow;

  // next-state: counter, exponent take-up, two-stage gate pipeline
  always_comb begin
    reqLog  = factorToLog(ctrl.factor);
    lastIdx = lastCount(curLog);
    run     = ctrl.enReq | syncA | syncB;
    wrap    = run && (cnt == lastIdx);
    if (!run || wrap) begin
      cntN   = '0;
      nxtLog = reqLog;
    end else begin
      cntN   = cnt + CNT_W'(1);
      nxtLog = curLog;
    end
    // stages step only at divided-clock period boundaries
    syncAN   = wrap ? ctrl.enReq : syncA;
    syncBN   = wrap ? syncA : syncB;
    lastIdxN = lastCount(nxtLog);
    // high during the first half of each period
    outRegN  = syncBN && (nxtLog != '0) && (cntN <= (lastIdxN >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      curLog <= '0;
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      outReg <= 1'b0;
    end else begin
      cnt    <= cntN;
      curLog <= nxtLog;
      syncA  <= syncAN;
      syncB  <= syncBN;
      outReg <= outRegN;
    end
  end

  // divide-by-one path: gate sampled while the reference is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gateLow <= 1'b0;
    else        gateLow <= syncB;
  end

  assign divClk = (curLog == '0) ? (clk & gateLow) : outReg;

  // R4: counter never passes the terminal count of the active divisor
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lastIdx);

  // R5: the gate opens only after the first stage has seen the request
  a_r5_sync_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncB) |-> $past(syncA));

  // R6: the gate changes only while the registered output is low
  a_r6_gate_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (syncB != $past(syncB)) |-> !$past(outReg));

  // R6: the gate closes at a period boundary
  a_r6_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncB) |-> (cnt == '0));

  // R7: mid-period the active exponent does not move
  a_r7_log_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (cnt != '0)) |-> $stable(curLog));
endmodule

// File: rtl/pow2_clock_divider.sv
module pow2_clock_divider
  import pow2div_pkg::*;
#(
  parameter int                         ADDR_W      = 16,
  parameter logic [ADDR_W-OFFSET_W-1:0] WINDOW_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              divClk
);
  ctrl_t ctrl;

  pow2div_regs #(
    .ADDR_W      (ADDR_W),
    .WINDOW_PAGE (WINDOW_PAGE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .ctrl     (ctrl)
  );

  pow2div_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .divClk (divClk)
  );
endmodule

// File: tb/pow2_clock_divider_bench.sv
module pow2_clock_divider_bench;
  localparam int CLK_PERIOD = 20;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam logic [15:0] FACTOR_ADDR = 16'h0143;
  localparam logic [15:0] ENABLE_ADDR = 16'h0146;
  localparam int NVEC = 8;
  localparam int VEC_FACTOR [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VEC_DIV    [NVEC] = '{1, 1, 2, 4, 8, 16, 32, 64};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        divClk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_clock_divider u_pow2_clock_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .divClk   (divClk)
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = '0; regWdata = '0;
  endtask

  task automatic readReg(input logic [15:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #QTR;
    v = int'(regRdata);
    regAddr = '0;
    @(negedge clk);
  endtask

  // samples every half reference cycle, starting a quarter cycle after a falling edge
  task automatic sampleWindow(input int n, input int divA, input int divB,
                              output int firstHigh, output int lastHigh, output int badRuns);
    int runLen;
    bit prev;
    bit cur;
    bit seenEdge;
    runLen = 0; prev = 1'b0; seenEdge = 1'b0;
    firstHigh = -1; lastHigh = -1; badRuns = 0;
    for (int k = 0; k < n; k++) begin
      #QTR;
      cur = divClk;
      if (k == 0) begin
        prev = cur; runLen = 1;
      end else if (cur == prev) begin
        runLen++;
      end else begin
        if (seenEdge && runLen != divA && runLen != divB) badRuns++;
        seenEdge = 1'b1; prev = cur; runLen = 1;
      end
      if (cur) begin
        if (firstHigh < 0) firstHigh = k;
        lastHigh = k;
      end
      #QTR;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, fh, lh, bad, d, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    readReg(FACTOR_ADDR, v);  check("R8", "factor after reset", v, 0);
    readReg(ENABLE_ADDR, v);  check("R8", "enable after reset", v, 0);
    sampleWindow(16, 1, 1, fh, lh, bad);
    check("R8", "output high after reset", lh, -1);
    readReg(16'h0144, v);     check("R8", "unmapped 0x44 read", v, 0);
    readReg(16'h0100, v);     check("R8", "unmapped 0x00 read", v, 0);

    // R2: only bits [2:0] stored
    writeReg(FACTOR_ADDR, 8'hFF);
    readReg(FACTOR_ADDR, v);  check("R2", "factor upper bits", v, 7);

    // R3: bits [6:0] of the enable write ignored
    writeReg(ENABLE_ADDR, 8'h7F);
    readReg(ENABLE_ADDR, v);  check("R3", "enable low bits ignored", v, 0);
    sampleWindow(64, 1, 1, fh, lh, bad);
    check("R3", "output stays low", lh, -1);

    // R1: another page is ignored and reads zero
    writeReg(16'h0246, 8'h80);
    readReg(ENABLE_ADDR, v);  check("R1", "foreign write ignored", v, 0);
    readReg(16'h0246, v);     check("R1", "foreign read zero", v, 0);
    sampleWindow(64, 1, 1, fh, lh, bad);
    check("R1", "output low after foreign write", lh, -1);

    // R4 R5 R6: every factor code
    for (int i = 0; i < NVEC; i++) begin
      d = VEC_DIV[i];
      writeReg(FACTOR_ADDR, 8'(VEC_FACTOR[i]));
      readReg(FACTOR_ADDR, v);
      check("R2", $sformatf("factor readback code %0d", VEC_FACTOR[i]), v, VEC_FACTOR[i]);
      writeReg(ENABLE_ADDR, 8'h80);
      n = 2 * (2 + 3 * d) + 6 * d;
      sampleWindow(n, d, d, fh, lh, bad);
      check("R5", $sformatf("started in time div %0d", d),
            int'(fh >= 0 && (fh + 1) <= 2 * (2 + 3 * d)), 1);
      check("R4", $sformatf("phase widths div %0d", d), bad, 0);
      readReg(ENABLE_ADDR, v);
      check("R3", "enable readback", v, 128);
      writeReg(ENABLE_ADDR, 8'h00);
      n = 10 * d;
      sampleWindow(n, d, d, fh, lh, bad);
      check("R6", $sformatf("stopped in time div %0d", d),
            int'(lh < 0 || (lh + 1) <= 2 * 3 * d), 1);
      check("R6", $sformatf("last pulse full div %0d", d), bad, 0);
    end

    // R7: factor changes while running
    writeReg(FACTOR_ADDR, 8'h03);
    writeReg(ENABLE_ADDR, 8'h80);
    sampleWindow(40, 4, 4, fh, lh, bad);
    check("R7", "running at div 4", bad, 0);
    writeReg(FACTOR_ADDR, 8'h01);
    readReg(FACTOR_ADDR, v);  check("R7", "factor written while enabled", v, 1);
    sampleWindow(48, 4, 1, fh, lh, bad);
    check("R7", "switch 4 to 1 no runt", bad, 0);
    sampleWindow(16, 1, 1, fh, lh, bad);
    check("R7", "settled at div 1", bad, 0);
    writeReg(FACTOR_ADDR, 8'h05);
    sampleWindow(80, 1, 16, fh, lh, bad);
    check("R7", "switch 1 to 16 no runt", bad, 0);
    sampleWindow(80, 16, 16, fh, lh, bad);
    check("R7", "settled at div 16", bad, 0);
    writeReg(ENABLE_ADDR, 8'h00);
    sampleWindow(160, 16, 16, fh, lh, bad);
    check("R6", "stopped after factor change", int'(lh < 0 || (lh + 1) <= 96), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule